// File: doc/BRIEF.md
# Inter-processor interrupt destination matcher

The block takes an interrupt command written as two 32-bit words and decides which of a set of processor slots should receive it. The high word holds the 8-bit destination. Writing the low word starts a dispatch. The low word carries the vector, the delivery mode, the physical/logical selector, the trigger mode and a two-bit destination shorthand.

For every slot, the block compares the command with that slot's physical ID, its logical ID and its addressing model, which is either flat or cluster. The source slot index settles the shorthand cases that include or exclude the sender. Fixed delivery raises an accept toward every slot that matches. Lowest-priority delivery reduces the matching set to a single slot. For one cycle the block presents a per-slot accept vector, together with the vector and the trigger mode. Each target slot handles acceptance itself.

Top module: `ipi_dest_match`

## Requirements
- R1: A write to the high word stores only bits [31:24], which hold the destination. Bits [23:0] always read back as 0.
- R2: A write to the low word stores the word with bit 12 forced to 0 and starts one dispatch. The accept outputs are valid in the cycle after the write edge and return to zero one cycle later unless another low-word write follows.
- R3: The shorthand sits in low-word bits [19:18]. Code 0 addresses by the destination field, 1 selects only the source slot, 2 selects every slot, and 3 selects every slot except the source.
- R4: In physical mode (low-word bit 11 = 0), a slot matches when the destination equals its 8-bit ID or equals 0xFF.
- R5: In logical mode (bit 11 = 1) with model code 4'hF (flat), a slot matches when its logical ID AND the destination is non-zero.
- R6: In logical mode with model code 4'h0 (cluster), a slot matches when the upper nibbles of its logical ID and the destination are equal and the lower nibbles share at least one set bit.
- R7: A model code other than 4'hF or 4'h0 gives no logical match.
- R8: Fixed delivery (mode bits [10:8] = 0) accepts every matching slot. The accept carries the vector from bits [7:0] and the trigger mode from bit 15.
- R9: Lowest-priority delivery (mode 1) accepts only the highest-numbered matching slot. When no slot matches, no accept is raised.
- R10: Delivery modes 2 to 7 raise no accept.
- R11: After reset both command words read 0 and no accept is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_hi_sel_i | input | 1 | 1 selects the high word, 0 selects the low word (dispatch) |
| cmd_wdata_i | input | 32 | Write data |
| slot_id_i | input | N*8 | Physical ID of each slot, with slot i at [8i+7:8i] |
| slot_lid_i | input | N*8 | Logical ID of each slot |
| slot_fmt_i | input | N*4 | Addressing model of each slot (4'hF flat, 4'h0 cluster) |
| src_slot_i | input | clog2(N) | Index of the sending slot |
| cmd_lo_o | output | 32 | Stored low word |
| cmd_hi_o | output | 32 | Stored high word |
| accept_o | output | N | One-cycle accept request per slot |
| acc_vec_o | output | 8 | Vector carried with the accept |
| acc_trig_o | output | 1 | Trigger mode carried with the accept |

## Verification
The stored command words change on the write edge and are read back at the next falling edge. An accept vector, its vector and its trigger mode appear one register stage after the low-word write edge, so the bench samples them at the falling edge that follows that edge. It then samples once more, one clock later, to confirm that the pulse has cleared. A reference function in the bench computes every expected accept mask from the slot configuration and the command words. The directed cases and the seeded random dispatches are all scored at those same two sample points.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_W = 8;
  localparam int DEST_LSB = 24;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  localparam int STATUS_BIT = 12;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    shorthand_e       sh;
    logic             trig;
    logic             logical;
    logic [2:0]       mode;
    logic [VEC_W-1:0] vec;
  } cmd_t;

  function automatic cmd_t decode_lo(input logic [31:0] w);
    cmd_t c;
    c.vec     = w[7:0];
    c.mode    = w[10:8];
    c.logical = w[11];
    c.trig    = w[15];
    c.sh      = shorthand_e'(w[19:18]);
    return c;
  endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        hi_sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lo_q_o,
  output logic [31:0] hi_q_o,
  output logic        dispatch_o
);
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q_o <= '0;
      hi_q_o <= '0;
    end else if (we_i) begin
      if (hi_sel_i) hi_q_o <= wdata_i & HI_KEEP;
      else          lo_q_o <= wdata_i & ~(32'd1 << STATUS_BIT);
    end
  end

  assign dispatch_o = we_i && !hi_sel_i;

  assert_hi_masked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q_o[23:0] == '0);
  assert_status_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_q_o[STATUS_BIT] == 1'b0);
endmodule

// File: rtl/ipi_slot_match.sv
module ipi_slot_match
  import ipi_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  shorthand_e      sh_i,
  input  logic            logical_i,
  input  logic [ID_W-1:0] dest_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] lid_i,
  input  logic [3:0]      fmt_i,
  input  logic            is_src_i,
  output logic            hit_o
);
  localparam int NIB = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST = '1;

  logic phys_hit, flat_hit, clus_hit, addr_hit;

  always_comb begin
    phys_hit = (dest_i == BCAST) || (dest_i == id_i);
    flat_hit = |(lid_i & dest_i);
    clus_hit = (lid_i[ID_W-1:NIB] == dest_i[ID_W-1:NIB]) &&
               (|(lid_i[NIB-1:0] & dest_i[NIB-1:0]));
    if (!logical_i)                addr_hit = phys_hit;
    else if (fmt_i == FMT_FLAT)    addr_hit = flat_hit;
    else if (fmt_i == FMT_CLUSTER) addr_hit = clus_hit;
    else                           addr_hit = 1'b0;
    unique case (sh_i)
      SH_DEST:   hit_o = addr_hit;
      SH_SELF:   hit_o = is_src_i;
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = !is_src_i;
      default:   hit_o = 1'b0;
    endcase
  end

  assert_self_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_i == SH_SELF && !is_src_i) |-> !hit_o);
  assert_bad_fmt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_i == SH_DEST && logical_i && fmt_i != FMT_FLAT && fmt_i != FMT_CLUSTER) |-> !hit_o);
endmodule

// File: rtl/ipi_deliver_sel.sv
module ipi_deliver_sel
  import ipi_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dispatch_i,
  input  logic [2:0]           mode_i,
  input  logic [VEC_W-1:0]     vec_i,
  input  logic                 trig_i,
  input  logic [NUM_SLOTS-1:0] hit_i,
  output logic [NUM_SLOTS-1:0] accept_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 trig_o
);
  logic [NUM_SLOTS-1:0] top_hit, sel;

  always_comb begin
    top_hit = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (hit_i[i]) top_hit = NUM_SLOTS'(1) << i;
  end

  always_comb begin
    if (!dispatch_i)              sel = '0;
    else if (mode_i == DM_FIXED)  sel = hit_i;
    else if (mode_i == DM_LOWEST) sel = top_hit;
    else                          sel = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= '0;
      vec_o    <= '0;
      trig_o   <= 1'b0;
    end else begin
      accept_o <= sel;
      if (dispatch_i) begin
        vec_o  <= vec_i;
        trig_o <= trig_i;
      end
    end
  end

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispatch_i |=> accept_o == '0);
  assert_lowest_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_i && mode_i == DM_LOWEST) |=> $onehot0(accept_o));
  assert_mode_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_i && mode_i != DM_FIXED && mode_i != DM_LOWEST) |=> accept_o == '0);
  assert_fixed_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_i && mode_i == DM_FIXED) |=> accept_o == $past(hit_i));
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 8,
  localparam int SRC_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_we_i,
  input  logic                   cmd_hi_sel_i,
  input  logic [31:0]            cmd_wdata_i,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id_i,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_lid_i,
  input  logic [NUM_SLOTS*4-1:0] slot_fmt_i,
  input  logic [SRC_W-1:0]       src_slot_i,
  output logic [31:0]            cmd_lo_o,
  output logic [31:0]            cmd_hi_o,
  output logic [NUM_SLOTS-1:0]   accept_o,
  output logic [VEC_W-1:0]       acc_vec_o,
  output logic                   acc_trig_o
);
  logic                 dispatch;
  cmd_t                 cmd;
  logic [ID_W-1:0]      dest;
  logic [NUM_SLOTS-1:0] hit;

  ipi_cmd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmd_we_i),
    .hi_sel_i  (cmd_hi_sel_i),
    .wdata_i   (cmd_wdata_i),
    .lo_q_o    (cmd_lo_o),
    .hi_q_o    (cmd_hi_o),
    .dispatch_o(dispatch)
  );

  // the dispatching word is decoded as written; destination comes from the stored high word
  assign cmd  = decode_lo(cmd_wdata_i);
  assign dest = cmd_hi_o[DEST_LSB +: ID_W];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    ipi_slot_match #(.ID_W(ID_W)) u_match (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sh_i     (cmd.sh),
      .logical_i(cmd.logical),
      .dest_i   (dest),
      .id_i     (slot_id_i[g*ID_W +: ID_W]),
      .lid_i    (slot_lid_i[g*ID_W +: ID_W]),
      .fmt_i    (slot_fmt_i[g*4 +: 4]),
      .is_src_i (src_slot_i == SRC_W'(g)),
      .hit_o    (hit[g])
    );
  end

  ipi_deliver_sel #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dispatch_i(dispatch),
    .mode_i    (cmd.mode),
    .vec_i     (cmd.vec),
    .trig_i    (cmd.trig),
    .hit_i     (hit),
    .accept_o  (accept_o),
    .vec_o     (acc_vec_o),
    .trig_o    (acc_trig_o)
  );
endmodule

// File: tb/tb_ipi_dest_match.sv
module tb_ipi_dest_match;
  localparam int N = 4;

  logic clk = 0, rst_ni = 0;
  logic cmd_we = 0, cmd_hi_sel = 0;
  logic [31:0] cmd_wdata = '0;
  logic [N*8-1:0] slot_id, slot_lid;
  logic [N*4-1:0] slot_fmt;
  logic [1:0] src = '0;
  logic [31:0] lo_o, hi_o;
  logic [N-1:0] accept;
  logic [7:0] acc_vec;
  logic acc_trig;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] ids [N];
  logic [7:0] lids[N];
  logic [3:0] fmts[N];

  always #10 clk = ~clk;

  ipi_dest_match #(.NUM_SLOTS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_hi_sel_i(cmd_hi_sel),
    .cmd_wdata_i(cmd_wdata), .slot_id_i(slot_id), .slot_lid_i(slot_lid),
    .slot_fmt_i(slot_fmt), .src_slot_i(src), .cmd_lo_o(lo_o), .cmd_hi_o(hi_o),
    .accept_o(accept), .acc_vec_o(acc_vec), .acc_trig_o(acc_trig)
  );

  always_comb
    for (int i = 0; i < N; i++) begin
      slot_id[i*8 +: 8]  = ids[i];
      slot_lid[i*8 +: 8] = lids[i];
      slot_fmt[i*4 +: 4] = fmts[i];
    end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                         input int s);
    logic [7:0] d = hi[31:24];
    logic [N-1:0] m = '0;
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      case (lo[19:18])
        2'd0: begin
          if (!lo[11]) m[i] = (d == 8'hFF) || (d == ids[i]);
          else if (fmts[i] == 4'hF) m[i] = (lids[i] & d) != 0;
          else if (fmts[i] == 4'h0)
            m[i] = (lids[i][7:4] == d[7:4]) && ((lids[i][3:0] & d[3:0]) != 0);
          else m[i] = 0;
        end
        2'd1: m[i] = (i == s);
        2'd2: m[i] = 1;
        default: m[i] = (i != s);
      endcase
    end
    if (lo[10:8] == 3'd0) return m;
    if (lo[10:8] == 3'd1) begin
      for (int i = N - 1; i >= 0; i--)
        if (m[i]) begin r[i] = 1; break; end
      return r;
    end
    return '0;
  endfunction

  task automatic wr(input logic hi_sel, input logic [31:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_hi_sel = hi_sel; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 0;
  endtask

  // write hi, then lo; after the lo edge sample at negedge, then one cycle later
  task automatic dispatch(input string tag, input logic [31:0] hi, input logic [31:0] lo,
                          input int s);
    logic [N-1:0] exp;
    wr(1'b1, hi);
    src = 2'(s);
    exp = model(lo, hi & 32'hFF00_0000, s);
    wr(1'b0, lo);
    check({tag, " accept"}, 32'(accept), 32'(exp));
    if (exp != 0) begin
      check({tag, " R8 vec"}, 32'(acc_vec), 32'(lo[7:0]));
      check({tag, " R8 trig"}, 32'(acc_trig), 32'(lo[15]));
    end
    @(negedge clk);
    check({tag, " R2 pulse end"}, 32'(accept), 0);
  endtask

  function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                        input logic logical, input logic trig,
                                        input logic [1:0] sh);
    return {12'h0, sh, 2'b0, trig, 3'b0, logical, mode, vec};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      ids[i] = 8'(16 * (i + 1)); lids[i] = 8'(1 << i); fmts[i] = 4'hF;
    end
    repeat (3) @(negedge clk);
    check("R11 accept", 32'(accept), 0);
    check("R11 lo", lo_o, 0);
    check("R11 hi", hi_o, 0);
    rst_ni = 1;

    wr(1'b1, 32'hABCD_EF12);
    check("R1 hi mask", hi_o, 32'hAB00_0000);
    wr(1'b0, 32'h0000_1234 | mk_lo(8'h40, 3'd5, 0, 0, 2'd2));
    check("R2 status cleared", lo_o, (32'h0000_1234 | mk_lo(8'h40, 3'd5, 0, 0, 2'd2)) & ~32'h1000);

    dispatch("R4 phys id", 32'h3000_0000, mk_lo(8'h55, 0, 0, 1, 0), 0);
    dispatch("R4 phys bcast", 32'hFF00_0000, mk_lo(8'h56, 0, 0, 0, 0), 0);
    dispatch("R5 flat", 32'h0500_0000, mk_lo(8'h60, 0, 1, 1, 0), 1);
    lids[0] = 8'h11; lids[1] = 8'h12; lids[2] = 8'h21; lids[3] = 8'h13;
    for (int i = 0; i < N; i++) fmts[i] = 4'h0;
    dispatch("R6 cluster", 32'h1300_0000, mk_lo(8'h61, 0, 1, 0, 0), 0);
    check("R6 mask", 32'(model(mk_lo(8'h61, 0, 1, 0, 0), 32'h1300_0000, 0)), 32'hB);
    for (int i = 0; i < N; i++) fmts[i] = 4'h5;
    dispatch("R7 bad fmt", 32'h1300_0000, mk_lo(8'h62, 0, 1, 0, 0), 0);
    for (int i = 0; i < N; i++) fmts[i] = 4'hF;
    dispatch("R3 self", 32'h0, mk_lo(8'h70, 0, 0, 0, 1), 2);
    dispatch("R3 all", 32'h0, mk_lo(8'h71, 0, 0, 0, 2), 2);
    dispatch("R3 others", 32'h0, mk_lo(8'h72, 0, 0, 0, 3), 2);
    dispatch("R9 lowest", 32'hFF00_0000, mk_lo(8'h80, 1, 0, 0, 0), 0);
    dispatch("R9 lowest none", 32'h7700_0000, mk_lo(8'h81, 1, 0, 0, 0), 0);
    dispatch("R10 nmi", 32'h0, mk_lo(8'h82, 3'd4, 0, 0, 2), 0);
    dispatch("R8 fixed all", 32'h0, mk_lo(8'hA5, 0, 0, 1, 2), 1);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] lo, hi;
      for (int i = 0; i < N; i++) begin
        ids[i]  = 8'($urandom_range(0, 7));
        lids[i] = 8'($urandom);
        case ($urandom_range(0, 3))
          0, 1: fmts[i] = 4'hF;
          2: fmts[i] = 4'h0;
          default: fmts[i] = 4'($urandom);
        endcase
      end
      lo = $urandom;
      lo[10:8] = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) lo[19:18] = 2'd0;
      hi = $urandom;
      if ($urandom_range(0, 3) == 0) hi[31:24] = 8'hFF;
      else if ($urandom_range(0, 1) == 1) hi[31:24] = 8'($urandom_range(0, 7));
      dispatch("R3/R4/R5/R6/R9 random", hi, lo, $urandom_range(0, N - 1));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule